// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block owns the control state a processor core needs when it enters an interrupt: the program counter, the status word, a 32-bit cause register and two pairs of saved-context registers. One pair is for the non-maskable interrupt and one is for the maskable sources. Requests arrive as single-cycle pulses on one non-maskable line and on six maskable lines. Each pulse sets a sticky pending flag. On every cycle the block checks the pending flags against the status word. If a request may be taken, the block saves the live program counter and status into the matching save pair, updates the status bits, writes a cause code and loads the program counter with a fixed vector.

The datapath drives the program counter and status word through plain write ports when no entry is happening. Two return pulses copy a save pair back into the live registers. One pulse returns from the non-maskable handler and the other returns from a maskable handler. The status bits used are: bit 7 marks a non-maskable handler in progress (NP), bit 6 marks exception processing (EP), and bit 5 disables maskable interrupts (ID).

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the program counter reads 0, the status word reads 0x0020, and the cause register and all four save registers read 0.
- R2: The non-maskable request is not taken while status bit 7 (NP) is set. Any number of pulses that arrive while one is already pending leave exactly one pending request, which produces exactly one entry.
- R3: A non-maskable entry has these effects. The program counter and status go into the non-maskable save pair. Cause bits 31:16 become 0. Cause bits 15:0 become their old value ORed with 0x0010. The status word gets bit 7 set, bit 6 cleared and bit 5 set. The program counter becomes 0x10.
- R4: A maskable request is not taken while status bit 7 or bit 5 is set, and its pending flag is kept until it is taken.
- R5: A maskable entry has these effects. The program counter and status go into the maskable save pair. The status word gets bit 5 set and bit 6 cleared. Cause bits 15:0 are replaced by the source code, and cause bits 31:16 keep their value.
- R6: Maskable source i (0 to 5) uses 0x80 + 0x10*i both as its vector and as its cause code.
- R7: When requests are pending together, the non-maskable one is taken first. Among maskable sources, the lowest index is taken first.
- R8: A request pulse sets its pending flag on the next rising edge. The entry is seen in the outputs after the edge that follows. The flag is cleared by its own entry, and repeated pulses while it is set give a single entry.
- R9: A return-from-NMI pulse loads the program counter and status from the non-maskable save pair. A return-from-interrupt pulse loads them from the maskable save pair. A simultaneous entry takes precedence over a return, and a return takes precedence over datapath writes.
- R10: When no entry or return occurs, the program counter write and the status write each load their data on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request pulse |
| irq_i | input | 6 | Maskable request pulses, index 0 highest priority |
| rfn_i | input | 1 | Return from non-maskable handler |
| rfi_i | input | 1 | Return from maskable handler |
| pc_we_i | input | 1 | Datapath program counter write enable |
| pc_wdata_i | input | 32 | Datapath program counter value |
| psw_we_i | input | 1 | Datapath status word write enable |
| psw_wdata_i | input | 16 | Datapath status word value |
| pc_o | output | 32 | Program counter |
| psw_o | output | 16 | Status word |
| ecr_o | output | 32 | Cause register |
| nmi_pc_o | output | 32 | Saved program counter, non-maskable |
| nmi_psw_o | output | 16 | Saved status, non-maskable |
| int_pc_o | output | 32 | Saved program counter, maskable |
| int_psw_o | output | 16 | Saved status, maskable |

## Verification
On every cycle, the assertions check the following: no entry happens while the blocking status bits are set; an entry leaves the vector, the status bits and the saved program counter as required; a blocked maskable flag is kept; and a return restores from the correct save pair. Some behaviour shows up only over whole sequences, so only the bench's scenarios can show it. This covers the collapse of repeated non-maskable pulses into one entry, the order in which simultaneous maskable requests are served across successive returns, and the cause register merging its two halves over a chain of entries.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned HALF   = XLEN / 2;
  localparam int unsigned PSW_W  = 16;
  localparam int unsigned NP_BIT = 7;
  localparam int unsigned EP_BIT = 6;
  localparam int unsigned ID_BIT = 5;

  localparam logic [PSW_W-1:0] PSW_RST  = PSW_W'(16'h0020);
  localparam logic [PSW_W-1:0] NP_MASK  = PSW_W'(1) << NP_BIT;
  localparam logic [PSW_W-1:0] EP_MASK  = PSW_W'(1) << EP_BIT;
  localparam logic [PSW_W-1:0] ID_MASK  = PSW_W'(1) << ID_BIT;
  localparam logic [XLEN-1:0]  NMI_VEC  = XLEN'(32'h10);
  localparam logic [HALF-1:0]  NMI_CODE = HALF'(16'h0010);
  localparam logic [XLEN-1:0]  IRQ_BASE = XLEN'(32'h80);
  localparam logic [XLEN-1:0]  IRQ_STEP = XLEN'(32'h10);

  function automatic logic [XLEN-1:0] irq_vector(input int unsigned idx);
    return IRQ_BASE + IRQ_STEP * XLEN'(idx);
  endfunction
endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             nmi_ok_i,
  input  logic             irq_ok_i,
  output logic             take_nmi_o,
  output logic             take_irq_o,
  output logic [IDX_W-1:0] take_idx_o
);
  logic             nmi_pend_q;
  logic [N_SRC-1:0] irq_pend_q;
  logic [N_SRC-1:0] irq_clr;
  logic             irq_any;

  // lowest index wins
  always_comb begin
    irq_any    = 1'b0;
    take_idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (irq_pend_q[i]) begin
        irq_any    = 1'b1;
        take_idx_o = IDX_W'(i);
      end
    end
  end

  assign take_nmi_o = nmi_pend_q && nmi_ok_i;
  assign take_irq_o = irq_any && irq_ok_i && !take_nmi_o;

  always_comb begin
    irq_clr = '0;
    if (take_irq_o) irq_clr[take_idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_pend_q <= 1'b0;
      irq_pend_q <= '0;
    end else begin
      nmi_pend_q <= (nmi_pend_q && !take_nmi_o) || nmi_i;
      irq_pend_q <= (irq_pend_q & ~irq_clr) | irq_i;
    end
  end

  a_r4_pend_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_irq_o |=> ((irq_pend_q & $past(irq_pend_q)) == $past(irq_pend_q)));
  a_r8_flag_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_nmi_o && !nmi_i) |=> !nmi_pend_q);
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_nmi_i,
  input  logic             take_irq_i,
  input  logic [IDX_W-1:0] take_idx_i,
  input  logic             rfn_i,
  input  logic             rfi_i,
  input  logic             pc_we_i,
  input  logic [XLEN-1:0]  pc_wdata_i,
  input  logic             psw_we_i,
  input  logic [PSW_W-1:0] psw_wdata_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [XLEN-1:0]  ecr_o,
  output logic [XLEN-1:0]  nmi_pc_o,
  output logic [PSW_W-1:0] nmi_psw_o,
  output logic [XLEN-1:0]  int_pc_o,
  output logic [PSW_W-1:0] int_psw_o
);
  logic [XLEN-1:0] irq_vec;
  assign irq_vec = irq_vector(int'(take_idx_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o      <= '0;
      psw_o     <= PSW_RST;
      ecr_o     <= '0;
      nmi_pc_o  <= '0;
      nmi_psw_o <= '0;
      int_pc_o  <= '0;
      int_psw_o <= '0;
    end else if (take_nmi_i) begin
      nmi_pc_o  <= pc_o;
      nmi_psw_o <= psw_o;
      ecr_o     <= {HALF'(0), ecr_o[HALF-1:0] | NMI_CODE};
      psw_o     <= (psw_o | NP_MASK | ID_MASK) & ~EP_MASK;
      pc_o      <= NMI_VEC;
    end else if (take_irq_i) begin
      int_pc_o  <= pc_o;
      int_psw_o <= psw_o;
      ecr_o     <= {ecr_o[XLEN-1:HALF], irq_vec[HALF-1:0]};
      psw_o     <= (psw_o | ID_MASK) & ~EP_MASK;
      pc_o      <= irq_vec;
    end else if (rfn_i) begin
      pc_o  <= nmi_pc_o;
      psw_o <= nmi_psw_o;
    end else if (rfi_i) begin
      pc_o  <= int_pc_o;
      psw_o <= int_psw_o;
    end else begin
      if (pc_we_i)  pc_o  <= pc_wdata_i;
      if (psw_we_i) psw_o <= psw_wdata_i;
    end
  end

  a_r3_nmi_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_nmi_i |=> (pc_o == NMI_VEC) && psw_o[NP_BIT] && psw_o[ID_BIT] && !psw_o[EP_BIT]
                   && (nmi_pc_o == $past(pc_o)) && (ecr_o[XLEN-1:HALF] == '0));
  a_r5_irq_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_i |=> psw_o[ID_BIT] && !psw_o[EP_BIT] && (int_pc_o == $past(pc_o))
                   && (ecr_o[XLEN-1:HALF] == $past(ecr_o[XLEN-1:HALF])));
  a_r9_rfn_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfn_i && !take_nmi_i && !take_irq_i) |=> (pc_o == $past(nmi_pc_o)) && (psw_o == $past(nmi_psw_o)));
  a_r9_rfi_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfi_i && !rfn_i && !take_nmi_i && !take_irq_i) |=> (pc_o == $past(int_pc_o)) && (psw_o == $past(int_psw_o)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             rfn_i,
  input  logic             rfi_i,
  input  logic             pc_we_i,
  input  logic [31:0]      pc_wdata_i,
  input  logic             psw_we_i,
  input  logic [15:0]      psw_wdata_i,
  output logic [31:0]      pc_o,
  output logic [15:0]      psw_o,
  output logic [31:0]      ecr_o,
  output logic [31:0]      nmi_pc_o,
  output logic [15:0]      nmi_psw_o,
  output logic [31:0]      int_pc_o,
  output logic [15:0]      int_psw_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             nmi_ok, irq_ok, take_nmi, take_irq;
  logic [IDX_W-1:0] take_idx;

  assign nmi_ok = !psw_o[NP_BIT];
  assign irq_ok = !psw_o[NP_BIT] && !psw_o[ID_BIT];

  irq_pend_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i, .rst_ni, .nmi_i, .irq_i,
    .nmi_ok_i   (nmi_ok),
    .irq_ok_i   (irq_ok),
    .take_nmi_o (take_nmi),
    .take_irq_o (take_irq),
    .take_idx_o (take_idx)
  );

  irq_ctx_regs #(.IDX_W(IDX_W)) u_ctx (
    .clk_i, .rst_ni,
    .take_nmi_i (take_nmi),
    .take_irq_i (take_irq),
    .take_idx_i (take_idx),
    .rfn_i, .rfi_i, .pc_we_i, .pc_wdata_i, .psw_we_i, .psw_wdata_i,
    .pc_o, .psw_o, .ecr_o, .nmi_pc_o, .nmi_psw_o, .int_pc_o, .int_psw_o
  );

  a_r2_nmi_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_o[NP_BIT] |-> !take_nmi);
  a_r4_irq_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_o[NP_BIT] || psw_o[ID_BIT]) |-> !take_irq);
  a_r6_vector_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq |=> (pc_o[3:0] == 4'h0) && (pc_o >= 32'h80) && (pc_o < 32'h80 + 32'h10 * N_SRC));
endmodule

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;

  logic clk = 0, rst_n = 0;
  logic nmi = 0, rfn = 0, rfi = 0, pc_we = 0, psw_we = 0;
  logic [NS-1:0] irq = '0;
  logic [31:0] pc_wd = '0;
  logic [15:0] psw_wd = '0;
  logic [31:0] pc, ecr, npc, ipc;
  logic [15:0] psw, npsw, ipsw;

  int total = 0, bad = 0;
  string cur_tag = "R1";
  bit done = 0;

  // reference model state
  logic [31:0] m_pc, m_ecr, m_npc, m_ipc;
  logic [15:0] m_psw, m_npsw, m_ipsw;
  logic        m_pn;
  logic [NS-1:0] m_pi;
  int m_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctrl #(.N_SRC(NS)) u_irq_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_i(irq), .rfn_i(rfn), .rfi_i(rfi),
    .pc_we_i(pc_we), .pc_wdata_i(pc_wd), .psw_we_i(psw_we), .psw_wdata_i(psw_wd),
    .pc_o(pc), .psw_o(psw), .ecr_o(ecr), .nmi_pc_o(npc), .nmi_psw_o(npsw),
    .int_pc_o(ipc), .int_psw_o(ipsw)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_psw = 16'h0020; m_ecr = 0; m_npc = 0; m_npsw = 0; m_ipc = 0; m_ipsw = 0;
      m_pn = 0; m_pi = '0;
    end else begin
      m_w = -1;
      for (int i = 0; i < NS; i++) if (m_pi[i] && m_w < 0) m_w = i;
      if (m_pn && !m_psw[7]) begin
        m_npc = m_pc; m_npsw = m_psw;
        m_ecr = {16'h0, m_ecr[15:0] | 16'h0010};
        m_psw = (m_psw | 16'h00a0) & ~16'h0040;
        m_pc = 32'h10; m_pn = 0;
      end else if (m_w >= 0 && !m_psw[7] && !m_psw[5]) begin
        m_ipc = m_pc; m_ipsw = m_psw;
        m_ecr = {m_ecr[31:16], 16'(32'h80 + 32'h10 * m_w)};
        m_psw = (m_psw | 16'h0020) & ~16'h0040;
        m_pc = 32'h80 + 32'h10 * m_w; m_pi[m_w] = 0;
      end else if (rfn) begin
        m_pc = m_npc; m_psw = m_npsw;
      end else if (rfi) begin
        m_pc = m_ipc; m_psw = m_ipsw;
      end else begin
        if (pc_we) m_pc = pc_wd;
        if (psw_we) m_psw = psw_wd;
      end
      m_pn = m_pn | nmi;
      m_pi = m_pi | irq;
    end
  end

  always @(negedge clk) if (!done) begin
    total++;
    if ({pc, psw, ecr, npc, npsw, ipc, ipsw} !== {m_pc, m_psw, m_ecr, m_npc, m_npsw, m_ipc, m_ipsw}) begin
      bad++;
      $display("FAIL %s cycle compare: act pc=%h psw=%h ecr=%h npc=%h npsw=%h ipc=%h ipsw=%h exp pc=%h psw=%h ecr=%h npc=%h npsw=%h ipc=%h ipsw=%h",
               cur_tag, pc, psw, ecr, npc, npsw, ipc, ipsw, m_pc, m_psw, m_ecr, m_npc, m_npsw, m_ipc, m_ipsw);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_irq(input logic [NS-1:0] v);
    irq = v; cyc(1); irq = '0;
  endtask
  task automatic p_nmi();
    nmi = 1; cyc(1); nmi = 0;
  endtask
  task automatic p_rfi();
    rfi = 1; cyc(1); rfi = 0;
  endtask
  task automatic p_rfn();
    rfn = 1; cyc(1); rfn = 0;
  endtask
  task automatic w_psw(input logic [15:0] v);
    psw_we = 1; psw_wd = v; cyc(1); psw_we = 0;
  endtask
  task automatic w_pc(input logic [31:0] v);
    pc_we = 1; pc_wd = v; cyc(1); pc_we = 0;
  endtask

  initial begin
    int nmi_hits;
    cyc(3);
    cur_tag = "R1";
    chk("R1 pc", pc, 0); chk("R1 psw", {16'h0, psw}, 32'h20); chk("R1 ecr", ecr, 0);
    rst_n = 1; cyc(1);

    cur_tag = "R4";
    p_irq(6'b000100); cyc(4);
    chk("R4 blocked by ID", pc, 0);
    cur_tag = "R10";
    w_psw(16'h0000);
    cyc(1);
    cur_tag = "R5";
    chk("R5/R6 vector src2", pc, 32'ha0);
    chk("R5 cause", ecr, 32'ha0);
    chk("R5 psw ID", {16'h0, psw}, 32'h20);

    cur_tag = "R10";
    w_pc(32'h500); chk("R10 pc write", pc, 32'h500);
    w_psw(16'h0021); chk("R10 psw write", {16'h0, psw}, 32'h21);
    cur_tag = "R9";
    p_rfi(); chk("R9 rfi pc", pc, 0); chk("R9 rfi psw", {16'h0, psw}, 0);

    cur_tag = "R7";
    w_pc(32'h40);
    p_irq(6'b001001); cyc(1);
    chk("R7 lowest first", pc, 32'h80);
    p_rfi(); cyc(1);
    chk("R7 next source", pc, 32'hb0);
    p_rfi(); cyc(1);
    chk("R7 back", pc, 32'h40);

    cur_tag = "R3";
    irq = 6'b100000; nmi = 1; cyc(1); irq = '0; nmi = 0; cyc(1);
    chk("R3/R7 nmi first", pc, 32'h10);
    chk("R3 psw", {16'h0, psw}, 32'ha0);
    chk("R3 saved pc", npc, 32'h40);

    cur_tag = "R2";
    p_nmi(); cyc(1); p_nmi(); p_nmi(); cyc(2);
    chk("R2 blocked by NP", npc, 32'h40);
    w_pc(32'h222);
    nmi_hits = 0;
    p_rfn();
    for (int k = 0; k < 6; k++) begin
      if (pc == 32'h10) nmi_hits++;
      if (pc == 32'h10) p_rfn(); else cyc(1);
    end
    chk("R2 one nmi entry", nmi_hits, 1);
    cur_tag = "R4";
    chk("R4 kept src5 taken", pc, 32'hd0);
    p_rfi();

    cur_tag = "R6";
    for (int s = 0; s < NS; s++) begin
      w_pc(32'h1000 + s);
      p_irq(NS'(1) << s); cyc(1);
      chk("R6 vector", pc, 32'h80 + 32'h10 * s);
      chk("R6 cause", {16'h0, ecr[15:0]}, 32'h80 + 32'h10 * s);
      p_rfi();
      chk("R9 return", pc, 32'h1000 + s);
    end

    cur_tag = "R8";
    w_psw(16'h0020);
    p_irq(6'b000010); p_irq(6'b000010); cyc(2);
    w_psw(16'h0000); cyc(1);
    chk("R8 entry", pc, 32'h90);
    p_rfi(); cyc(3);
    chk("R8 single entry", pc, 32'h1005);

    cur_tag = "R9";
    p_nmi(); rfi = 1; cyc(1); rfi = 0;
    chk("R9 entry beats return", pc, 32'h10);
    p_rfn();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule